// File: doc/BRIEF.md
# Request/Response Link Rule Monitor

This block watches a link that has two valid/ready channels: a request channel that carries address, direction, write data, byte enables, an access size and an operation code, and a response channel that carries read data and an error bit. It only listens. It never drives the link. It checks that both sides follow the handshake rules. It keeps a count of accepted requests that still wait for a response. It also checks that every atomic, load-reserve and store-conditional request has a legal operation code, direction and size, and that its address is naturally aligned.

When a cycle breaks one or more rules, the monitor raises a one-cycle strobe at the next clock edge and outputs a numeric code for the broken rule. If several rules break in the same cycle, the lowest code is reported. The outstanding count is a registered output, so a bench or an embedded debug path can read it. The count also drives a stall timer. The timer flags a request that gets no response within a set number of cycles.

Top module: `link_rule_monitor`

## Requirements
- R1: While reset is high, and in the first cycle after it, `viol_strobe` is 0, `viol_code` is 0 and `outstanding` is 0.
- R2: A transfer happens in any cycle where valid and ready are both high. If `req_valid` is high without a transfer and then goes low in the next cycle, code 1 is reported, and the count does not change.
- R3: If `req_valid` is high without a transfer and any request field (address, direction, write data, byte enables, size, operation code) differs in the next cycle while valid stays high, code 2 is reported.
- R4: Valid rising in the cycle right after its channel's ready rose from low to high, while valid was low, is reported as valid that waited for ready. This is code 3 on the request channel and code 6 on the response channel.
- R5: The response channel follows the same hold rules as the request channel. A dropped `rsp_valid` is code 4 and changed response fields are code 5.
- R6: `outstanding` goes up by one after each request transfer and down by one after each response transfer. If both transfer in the same cycle, it does not change. It saturates at its maximum.
- R7: A response transfer while `outstanding` is 0 is reported as code 7, and the count stays at 0.
- R8: When `outstanding` is nonzero and no response transfers for TIMEOUT cycles in a row, code 8 is reported once, in the TIMEOUT-th such cycle. It is not reported again until a response transfers or the count returns to 0.
- R9: A request transfer with operation code 12 to 15 is code 9. The operation codes are: 0 plain access, 1 to 9 atomic memory operations, 10 load-reserve, 11 store-conditional.
- R10: A request transfer is code 10 if it is an atomic operation or a store-conditional with `req_write` = 0, or a load-reserve with `req_write` = 1.
- R11: A request transfer with operation code 1 to 11 is code 11 unless `req_size` is 2 (4 bytes) or 3 (8 bytes). Size 3 is legal only when the data bus is at least 64 bits. The number of bytes is 2 to the power of `req_size`.
- R12: A request transfer with operation code 1 to 11 and a legal size is code 12 if any address bit below the size in bytes is set.
- R13: Only one code is reported per cycle, and it is the lowest code among the rules broken. The strobe appears one cycle after the offending cycle, and the code is 0 whenever the strobe is low.
- R14: Plain accesses (code 0) are not checked by the operation rules, whatever their size, alignment or direction. Traffic that follows all rules produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request channel valid |
| req_ready | input | 1 | Request channel ready |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | Request direction, 1 = write |
| req_wdata | input | DATA_W | Request write data |
| req_strb | input | DATA_W/8 | Request byte enables |
| req_size | input | SIZE_W | Access size as log2 of the byte count |
| req_op | input | 4 | Operation code (0 plain, 1-9 atomic, 10 reserve, 11 conditional store) |
| rsp_valid | input | 1 | Response channel valid |
| rsp_ready | input | 1 | Response channel ready |
| rsp_rdata | input | DATA_W | Response data |
| rsp_err | input | 1 | Response error flag |
| viol_strobe | output | 1 | One-cycle rule-violation pulse |
| viol_code | output | 4 | Code of the reported rule, 0 when quiet |
| outstanding | output | CNT_W | Accepted requests still waiting for a response |

## Verification
The hardest case to reach is a cycle where two rules break at once and only the lower code must appear. The bench holds `rsp_valid` high with `rsp_ready` low while nothing is outstanding. It then changes the response data in the same cycle it raises ready. This produces a changed-payload violation and an orphan response together, and code 5 must win. The stall timer is checked at the exact cycle: it must still be quiet one cycle before the limit and must have fired right after. It is then held stalled much longer to show that it fires only once.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  typedef enum logic [3:0] {
    V_NONE      = 4'd0,
    V_REQ_DROP  = 4'd1,
    V_REQ_SHIFT = 4'd2,
    V_REQ_EARLY = 4'd3,
    V_RSP_DROP  = 4'd4,
    V_RSP_SHIFT = 4'd5,
    V_RSP_EARLY = 4'd6,
    V_ORPHAN    = 4'd7,
    V_STALL     = 4'd8,
    V_OP_CODE   = 4'd9,
    V_OP_DIR    = 4'd10,
    V_OP_SIZE   = 4'd11,
    V_OP_ALIGN  = 4'd12
  } viol_e;

  localparam int NUM_RULES = 13;
  localparam int OP_W      = 4;

  localparam logic [OP_W-1:0] OP_PLAIN   = 4'd0;
  localparam logic [OP_W-1:0] OP_AMO_LO  = 4'd1;
  localparam logic [OP_W-1:0] OP_AMO_HI  = 4'd9;
  localparam logic [OP_W-1:0] OP_RESERVE = 4'd10;
  localparam logic [OP_W-1:0] OP_COND_ST = 4'd11;

endpackage

// File: rtl/lrm_chan_watch.sv
// Hold-rule watcher for one valid/ready channel. Outputs are combinational
// hits for the current cycle, judged against the registered previous cycle.
module lrm_chan_watch #(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic                 ready,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 drop,
  output logic                 shift,
  output logic                 early
);

  logic                 prev_valid;
  logic                 prev_ready;
  logic                 prev2_ready;
  logic [PAYLOAD_W-1:0] prev_payload;
  logic                 waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid   <= 1'b0;
      prev_ready   <= 1'b0;
      prev2_ready  <= 1'b0;
      prev_payload <= '0;
    end else begin
      prev_valid   <= valid;
      prev_ready   <= ready;
      prev2_ready  <= prev_ready;
      prev_payload <= payload;
    end
  end

  always_comb begin
    waiting = prev_valid && !prev_ready;
    drop    = waiting && !valid;
    shift   = waiting && valid && (payload != prev_payload);
    // valid rose right after ready rose on an idle channel
    early   = valid && !prev_valid && prev_ready && !prev2_ready;
  end

endmodule

// File: rtl/lrm_op_rules.sv
// Legality of operation code, direction, size and alignment for a request.
module lrm_op_rules
  import lrm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 3
) (
  input  logic [OP_W-1:0]   op,
  input  logic              write,
  input  logic [SIZE_W-1:0] size,
  input  logic [2:0]        addr_lo,
  output logic              bad_code,
  output logic              bad_dir,
  output logic              bad_size,
  output logic              bad_align
);

  localparam bit WIDE_OK = (DATA_W >= 64);

  logic       is_amo;
  logic       is_res;
  logic       is_cst;
  logic       special;
  logic       size_ok;
  logic [2:0] mask;

  always_comb begin
    is_amo  = (op >= OP_AMO_LO) && (op <= OP_AMO_HI);
    is_res  = (op == OP_RESERVE);
    is_cst  = (op == OP_COND_ST);
    special = is_amo || is_res || is_cst;

    bad_code = (op > OP_COND_ST);

    if (is_amo || is_cst) bad_dir = !write;
    else if (is_res)      bad_dir = write;
    else                  bad_dir = 1'b0;

    size_ok  = (size == SIZE_W'(2)) || (WIDE_OK && (size == SIZE_W'(3)));
    bad_size = special && !size_ok;

    if (size == SIZE_W'(3))      mask = 3'b111;
    else if (size == SIZE_W'(2)) mask = 3'b011;
    else                         mask = 3'b000;
    bad_align = special && size_ok && (|(addr_lo & mask));
  end

endmodule

// File: rtl/lrm_tally.sv
// Outstanding-request counter with orphan detection and a stall timer.
module lrm_tally #(
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_fire,
  input  logic             rsp_fire,
  output logic [CNT_W-1:0] count,
  output logic             orphan,
  output logic             stall
);

  localparam int               WAIT_W  = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WAIT_W-1:0] wait_q;
  logic              inc;
  logic              dec;

  always_comb begin
    inc    = req_fire && (count != CNT_MAX);
    dec    = rsp_fire && (count != '0);
    orphan = rsp_fire && (count == '0);
    stall  = (count != '0) && !rsp_fire && (wait_q == WAIT_W'(TIMEOUT - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && !dec) begin
      count <= count + 1'b1;
    end else if (dec && !inc) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || count == '0 || rsp_fire) begin
      wait_q <= '0;
    end else if (wait_q != WAIT_W'(TIMEOUT)) begin
      wait_q <= wait_q + 1'b1;
    end
  end

endmodule

// File: rtl/link_rule_monitor.sv
module link_rule_monitor
  import lrm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int SIZE_W  = 3,
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_strb,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic [3:0]           req_op,
  input  logic                 rsp_valid,
  input  logic                 rsp_ready,
  input  logic [DATA_W-1:0]    rsp_rdata,
  input  logic                 rsp_err,
  output logic                 viol_strobe,
  output logic [3:0]           viol_code,
  output logic [CNT_W-1:0]     outstanding
);

  localparam int STRB_W = DATA_W / 8;
  localparam int REQ_PW = ADDR_W + 1 + DATA_W + STRB_W + SIZE_W + OP_W;
  localparam int RSP_PW = DATA_W + 1;

  logic req_fire;
  logic rsp_fire;
  logic q_drop, q_shift, q_early;
  logic p_drop, p_shift, p_early;
  logic t_orphan, t_stall;
  logic o_code, o_dir, o_size, o_align;
  logic [NUM_RULES-1:0] hits;
  viol_e code_d;

  assign req_fire = req_valid && req_ready;
  assign rsp_fire = rsp_valid && rsp_ready;

  lrm_chan_watch #(.PAYLOAD_W(REQ_PW)) u_req_watch (
    .clk     (clk),
    .rst     (rst),
    .valid   (req_valid),
    .ready   (req_ready),
    .payload ({req_addr, req_write, req_wdata, req_strb, req_size, req_op}),
    .drop    (q_drop),
    .shift   (q_shift),
    .early   (q_early)
  );

  lrm_chan_watch #(.PAYLOAD_W(RSP_PW)) u_rsp_watch (
    .clk     (clk),
    .rst     (rst),
    .valid   (rsp_valid),
    .ready   (rsp_ready),
    .payload ({rsp_rdata, rsp_err}),
    .drop    (p_drop),
    .shift   (p_shift),
    .early   (p_early)
  );

  lrm_op_rules #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_op_rules (
    .op        (req_op),
    .write     (req_write),
    .size      (req_size),
    .addr_lo   (req_addr[2:0]),
    .bad_code  (o_code),
    .bad_dir   (o_dir),
    .bad_size  (o_size),
    .bad_align (o_align)
  );

  lrm_tally #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_tally (
    .clk      (clk),
    .rst      (rst),
    .req_fire (req_fire),
    .rsp_fire (rsp_fire),
    .count    (outstanding),
    .orphan   (t_orphan),
    .stall    (t_stall)
  );

  always_comb begin
    hits                   = '0;
    hits[int'(V_REQ_DROP)]  = q_drop;
    hits[int'(V_REQ_SHIFT)] = q_shift;
    hits[int'(V_REQ_EARLY)] = q_early;
    hits[int'(V_RSP_DROP)]  = p_drop;
    hits[int'(V_RSP_SHIFT)] = p_shift;
    hits[int'(V_RSP_EARLY)] = p_early;
    hits[int'(V_ORPHAN)]    = t_orphan;
    hits[int'(V_STALL)]     = t_stall;
    hits[int'(V_OP_CODE)]   = req_fire && o_code;
    hits[int'(V_OP_DIR)]    = req_fire && o_dir;
    hits[int'(V_OP_SIZE)]   = req_fire && o_size;
    hits[int'(V_OP_ALIGN)]  = req_fire && o_align;
  end

  // lowest-numbered rule wins: scan downwards, last match sticks
  always_comb begin
    code_d = V_NONE;
    for (int i = NUM_RULES - 1; i >= 1; i--) begin
      if (hits[i]) code_d = viol_e'(i[3:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_strobe <= 1'b0;
      viol_code   <= 4'd0;
    end else begin
      viol_strobe <= (code_d != V_NONE);
      viol_code   <= code_d;
    end
  end

endmodule

// File: rtl/lrm_props.sv
module lrm_props #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_op,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             viol_strobe,
  input logic [CNT_W-1:0] outstanding
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_req_drop_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(req_valid && !req_ready) && !req_valid |=> viol_strobe);

  p_rsp_drop_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(rsp_valid && !rsp_ready) && !rsp_valid |=> viol_strobe);

  p_count_up_r6: assert property (@(posedge clk) disable iff (rst)
    armed && $past(req_valid && req_ready && !(rsp_valid && rsp_ready))
          && ($past(outstanding) != CNT_MAX)
    |-> outstanding == $past(outstanding) + 1'b1);

  p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) && !(rsp_valid && rsp_ready)
    |=> $stable(outstanding));

  p_orphan_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready && (outstanding == '0) |=> viol_strobe);

  p_bad_op_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_op > 4'd11) |=> viol_strobe);

endmodule

bind link_rule_monitor lrm_props #(.CNT_W(CNT_W)) u_props (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .viol_strobe (viol_strobe),
  .outstanding (outstanding)
);

// File: tb/link_rule_monitor_test.sv
`timescale 1ns/1ps
module link_rule_monitor_test;

  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 64;
  localparam int SIZE_W  = 3;
  localparam int CNT_W   = 8;
  localparam int TIMEOUT = 16;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic                req_ready = 1'b1;
  logic [ADDR_W-1:0]   req_addr = '0;
  logic                req_write = 1'b0;
  logic [DATA_W-1:0]   req_wdata = '0;
  logic [DATA_W/8-1:0] req_strb = '0;
  logic [SIZE_W-1:0]   req_size = '0;
  logic [3:0]          req_op = '0;
  logic                rsp_valid = 1'b0;
  logic                rsp_ready = 1'b1;
  logic [DATA_W-1:0]   rsp_rdata = '0;
  logic                rsp_err = 1'b0;
  logic                viol_strobe;
  logic [3:0]          viol_code;
  logic [CNT_W-1:0]    outstanding;

  int checks = 0;
  int fails  = 0;
  int    exp_code[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  link_rule_monitor #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .CNT_W(CNT_W), .TIMEOUT(TIMEOUT)
  ) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_strb(req_strb),
    .req_size(req_size), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err),
    .viol_strobe(viol_strobe), .viol_code(viol_code), .outstanding(outstanding)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_viol(input int code, input string tag);
    exp_code.push_back(code);
    exp_tag.push_back(tag);
  endtask

  task automatic set_req(input logic [ADDR_W-1:0] a, input logic w,
                         input logic [SIZE_W-1:0] s, input logic [3:0] op);
    req_addr  = a;
    req_write = w;
    req_size  = s;
    req_op    = op;
    req_wdata = {a, ~a};
    req_strb  = '1;
  endtask

  task automatic send_req(input logic [ADDR_W-1:0] a, input logic w,
                          input logic [SIZE_W-1:0] s, input logic [3:0] op);
    set_req(a, w, s, op);
    req_valid = 1'b1;
    tick(1);
    req_valid = 1'b0;
  endtask

  task automatic respond(input logic [DATA_W-1:0] d);
    rsp_rdata = d;
    rsp_valid = 1'b1;
    tick(1);
    rsp_valid = 1'b0;
  endtask

  // scoreboard monitor: every strobe must match the oldest expected code
  always @(negedge clk) begin
    if (!rst && viol_strobe) begin
      if (exp_code.size() == 0) begin
        check(1'b0, "R13 unexpected strobe", int'(viol_code), 0);
      end else begin
        int    e;
        string t;
        e = exp_code.pop_front();
        t = exp_tag.pop_front();
        check(int'(viol_code) == e, t, int'(viol_code), e);
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset state
    tick(3);
    check(viol_strobe == 1'b0, "R1 strobe in reset", int'(viol_strobe), 0);
    check(viol_code == 4'd0, "R1 code in reset", int'(viol_code), 0);
    check(outstanding == '0, "R1 count in reset", int'(outstanding), 0);
    rst = 1'b0;
    tick(1);
    check(viol_strobe == 1'b0 && outstanding == '0, "R1 after reset", int'(outstanding), 0);
    tick(3);

    // R6 / R14: legal plain traffic, back to back
    set_req(32'h40, 1'b1, 3'd0, 4'd0);
    req_valid = 1'b1;
    tick(3);
    req_valid = 1'b0;
    check(outstanding == 8'd3, "R6 count after three requests", int'(outstanding), 3);
    req_valid = 1'b1;
    rsp_valid = 1'b1;
    tick(1);
    req_valid = 1'b0;
    rsp_valid = 1'b0;
    check(outstanding == 8'd3, "R6 count with same-cycle pair", int'(outstanding), 3);
    rsp_valid = 1'b1;
    tick(3);
    rsp_valid = 1'b0;
    check(outstanding == 8'd0, "R6 count drained", int'(outstanding), 0);
    tick(2);

    // R2: request dropped before transfer
    req_ready = 1'b0;
    set_req(32'h80, 1'b0, 3'd2, 4'd0);
    req_valid = 1'b1;
    tick(1);
    expect_viol(1, "R2 request drop code");
    req_valid = 1'b0;
    tick(1);
    req_ready = 1'b1;
    tick(3);
    check(outstanding == 8'd0, "R2 dropped request not counted", int'(outstanding), 0);

    // R3: payload change while waiting
    req_ready = 1'b0;
    set_req(32'h100, 1'b1, 3'd2, 4'd0);
    req_valid = 1'b1;
    tick(1);
    expect_viol(2, "R3 request payload change code");
    set_req(32'h104, 1'b1, 3'd2, 4'd0);
    tick(1);
    req_ready = 1'b1;
    tick(1);
    req_valid = 1'b0;
    tick(3);
    check(outstanding == 8'd1, "R3 held request counted once", int'(outstanding), 1);
    respond(64'h11);
    tick(1);

    // R4: request valid follows ready
    req_ready = 1'b0;
    tick(1);
    req_ready = 1'b1;
    tick(1);
    expect_viol(3, "R4 request valid after ready");
    send_req(32'h200, 1'b0, 3'd2, 4'd0);
    tick(1);
    respond(64'h22);
    tick(1);
    // R4: response valid follows ready
    send_req(32'h210, 1'b0, 3'd2, 4'd0);
    rsp_ready = 1'b0;
    tick(1);
    rsp_ready = 1'b1;
    tick(1);
    expect_viol(6, "R4 response valid after ready");
    respond(64'h33);
    tick(2);
    check(outstanding == 8'd0, "R4 count after early response", int'(outstanding), 0);

    // R5: response drop and response change
    send_req(32'h300, 1'b0, 3'd2, 4'd0);
    rsp_ready = 1'b0;
    rsp_valid = 1'b1;
    tick(1);
    expect_viol(4, "R5 response drop code");
    rsp_valid = 1'b0;
    tick(1);
    rsp_ready = 1'b1;
    tick(3);
    check(outstanding == 8'd1, "R5 dropped response not counted", int'(outstanding), 1);
    rsp_ready = 1'b0;
    rsp_rdata = 64'hA;
    rsp_valid = 1'b1;
    tick(1);
    expect_viol(5, "R5 response payload change code");
    rsp_rdata = 64'hB;
    tick(1);
    rsp_ready = 1'b1;
    tick(1);
    rsp_valid = 1'b0;
    tick(2);
    check(outstanding == 8'd0, "R5 changed response still counted", int'(outstanding), 0);

    // R7: orphan response
    expect_viol(7, "R7 orphan response code");
    respond(64'h44);
    tick(2);
    check(outstanding == 8'd0, "R7 count stays zero", int'(outstanding), 0);

    // R13: change and orphan in one cycle, code 5 wins over 7
    rsp_ready = 1'b0;
    rsp_rdata = 64'hC;
    rsp_valid = 1'b1;
    tick(1);
    expect_viol(5, "R13 lowest code wins");
    rsp_rdata = 64'hD;
    rsp_ready = 1'b1;
    tick(1);
    rsp_valid = 1'b0;
    tick(2);
    check(outstanding == 8'd0, "R13 count after combined case", int'(outstanding), 0);

    // R8: stall timer, exact cycle and single report
    send_req(32'h400, 1'b0, 3'd3, 4'd0);
    tick(TIMEOUT - 1);
    check(viol_strobe == 1'b0, "R8 quiet one cycle before limit", int'(viol_strobe), 0);
    expect_viol(8, "R8 stall code");
    tick(1);
    #1;
    check(exp_code.size() == 0, "R8 stall reported at limit", exp_code.size(), 0);
    tick(40);
    respond(64'h55);
    tick(2);
    check(outstanding == 8'd0, "R8 count after late response", int'(outstanding), 0);

    // R9..R12, R14: operation rules
    expect_viol(10, "R10 atomic without write");
    send_req(32'h500, 1'b0, 3'd2, 4'd1);  respond(64'h1); tick(1);
    expect_viol(10, "R10 reserve with write");
    send_req(32'h504, 1'b1, 3'd2, 4'd10); respond(64'h2); tick(1);
    expect_viol(9, "R9 illegal operation code");
    send_req(32'h508, 1'b1, 3'd2, 4'd13); respond(64'h3); tick(1);
    expect_viol(9, "R9 illegal code with bad size");
    send_req(32'h509, 1'b1, 3'd7, 4'd12); respond(64'h3); tick(1);
    expect_viol(11, "R11 atomic of two bytes");
    send_req(32'h510, 1'b1, 3'd1, 4'd2);  respond(64'h4); tick(1);
    expect_viol(12, "R12 eight-byte atomic misaligned");
    send_req(32'h514, 1'b1, 3'd3, 4'd6);  respond(64'h5); tick(1);
    expect_viol(12, "R12 conditional store misaligned");
    send_req(32'h522, 1'b1, 3'd2, 4'd11); respond(64'h6); tick(1);
    expect_viol(10, "R13 direction beats size");
    send_req(32'h531, 1'b0, 3'd1, 4'd1);  respond(64'h7); tick(1);
    // legal ones: no strobe expected
    send_req(32'h608, 1'b1, 3'd3, 4'd7);  respond(64'h8); tick(1);
    send_req(32'h614, 1'b0, 3'd2, 4'd10); respond(64'h9); tick(1);
    send_req(32'h623, 1'b1, 3'd0, 4'd0);  respond(64'hA); tick(1);
    send_req(32'h62C, 1'b1, 3'd2, 4'd11); respond(64'hB); tick(1);

    tick(5);
    check(exp_code.size() == 0, "R14 all expected codes seen", exp_code.size(), 0);
    check(outstanding == 8'd0, "R6 final count", int'(outstanding), 0);
    check(viol_strobe == 1'b0 && viol_code == 4'd0, "R13 quiet code is zero",
          int'(viol_code), 0);
    finish_run();
  end

endmodule